// File: doc/BRIEF.md
# Switch and Button Input Conditioner

This block cleans up the slide switches and push buttons of a development board before internal logic reads them. A 16-bit switch vector and a 4-bit button vector enter asynchronously. Each bit first passes through a two-flop synchronizer. Every register runs on the single system clock. Slow timing comes from a free-running divider that raises a one-cycle enable strobe. No register is clocked by a derived signal.

On the strobes, the block works in alternating phases. On one strobe it captures the synchronized group value. On the next strobe it compares the current synchronized value with that capture. If the two match, the value moves to the clean output; if not, the old clean value stays. The switch group and the button group each do their own comparison, so contact bounce in one group never holds back an update in the other. Internal logic reads only the clean vectors.

Top module: `switch_debounce`

## Requirements
- R1: Reset is asynchronous and active high. While it is asserted, both clean outputs read all zeros, without waiting for a clock edge.
- R2: A group value held stable on the raw inputs appears unchanged on that group's clean output no later than 4*(TICK_MAX+1)+4 clock cycles after it is applied.
- R3: The strobe is one cycle wide and repeats every TICK_MAX+1 cycles, the divider counting 0..TICK_MAX. Clean outputs change only on compare strobes, which come on every second strobe, so any two output changes are an integer multiple of 2*(TICK_MAX+1) cycles apart.
- R4: A raw disturbance shorter than one strobe period, after which the input returns to its earlier value, leaves the clean output unchanged.
- R5: The switch and button groups are compared separately. A group whose raw value keeps changing does not stop a stable group from updating, and it keeps its own clean value.
- R6: Each raw bit passes through two synchronizer flops, so the clean output cannot change within two clock edges of a raw input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock |
| rst | input | 1 | Asynchronous active-high reset |
| sw_raw | input | SW_W (16) | Raw slide-switch levels |
| btn_raw | input | BTN_W (4) | Raw push-button levels |
| sw_clean | output | SW_W (16) | Debounced switch vector |
| btn_clean | output | BTN_W (4) | Debounced button vector |

## Verification
On every cycle the assertions check four things: the strobe lasts one cycle, the capture/compare phase moves only on strobes, a clean output never changes without a strobe in the previous cycle, and a compare strobe either copies a matching sample or leaves the output alone on a mismatch. The bench scenarios cover what needs a whole input history. These are the latency bound for stable inputs, rejection of short glitches at every alignment to the strobe, the group independence under steady bouncing, the lower bound set by the synchronizer, and the spacing of output changes across a full run.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    typedef enum logic {
        PH_CAPTURE = 1'b0,
        PH_COMPARE = 1'b1
    } phase_e;
endpackage

// File: rtl/sbd_sync.sv
module sbd_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_out = st_q.stable;

    // R6: the second stage follows the first stage one cycle later
    p_two_stage_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> st_q.stable == $past(st_q.meta));
endmodule

// File: rtl/sbd_strobe.sv
module sbd_strobe #(
    parameter int TICK_MAX = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(TICK_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (dv_q.cnt == CW'(TICK_MAX)) begin
            dv_d.cnt  = '0;
            dv_d.tick = 1'b1;
        end else begin
            dv_d.cnt  = dv_q.cnt + 1'b1;
            dv_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) dv_q <= '0;
        else     dv_q <= dv_d;
    end

    assign tick = dv_q.tick;

    // R3: the strobe is exactly one cycle wide
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        dv_q.tick |=> !dv_q.tick);
endmodule

// File: rtl/sbd_group.sv
module sbd_group
    import sbd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] sync_in,
    output logic [W-1:0] clean
);
    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] cap;
        logic [W-1:0] clean;
    } grp_t;

    grp_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (tick) begin
            if (g_q.phase == PH_CAPTURE) begin
                g_d.cap   = sync_in;
                g_d.phase = PH_COMPARE;
            end else begin
                if (sync_in == g_q.cap) g_d.clean = sync_in;
                g_d.phase = PH_CAPTURE;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) g_q <= '{phase: PH_CAPTURE, cap: '0, clean: '0};
        else     g_q <= g_d;
    end

    assign clean = g_q.clean;

    // R1: clean output reads zero whenever reset is high
    always @(posedge clk) begin
        if (rst) p_clear_r1: assert (clean == '0);
    end

    // R3: no change of the clean value without a strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(clean));

    // R3: the phase moves only on strobes
    p_phase_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(g_q.phase));

    // R2: a matching pair is published
    p_agree_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && g_q.phase == PH_COMPARE && sync_in == g_q.cap)
        |=> clean == $past(sync_in));

    // R4: a mismatching pair leaves the output alone
    p_reject_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && g_q.phase == PH_COMPARE && sync_in != g_q.cap)
        |=> $stable(clean));
endmodule

// File: rtl/switch_debounce.sv
module switch_debounce #(
    parameter int SW_W     = 16,
    parameter int BTN_W    = 4,
    parameter int TICK_MAX = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW_W-1:0]  sw_raw,
    input  logic [BTN_W-1:0] btn_raw,
    output logic [SW_W-1:0]  sw_clean,
    output logic [BTN_W-1:0] btn_clean
);
    localparam int ALL_W = SW_W + BTN_W;

    logic [ALL_W-1:0] sync_all;
    logic             tick;

    sbd_sync #(.W(ALL_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   ({btn_raw, sw_raw}),
        .sync_out (sync_all)
    );

    sbd_strobe #(.TICK_MAX(TICK_MAX)) u_strobe (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sbd_group #(.W(SW_W)) u_sw_grp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .sync_in (sync_all[SW_W-1:0]),
        .clean   (sw_clean)
    );

    sbd_group #(.W(BTN_W)) u_btn_grp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .sync_in (sync_all[ALL_W-1:SW_W]),
        .clean   (btn_clean)
    );

    // R5: both groups see the same strobe, so neither moves off a strobe
    p_groups_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(sw_clean) && $stable(btn_clean)));
endmodule

// File: tb/switch_debounce_tb.sv
module switch_debounce_tb;
    localparam int TICK   = 9;
    localparam int PER    = TICK + 1;
    localparam int PAIR   = 2 * PER;
    localparam int BOUND  = 4 * PER + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sw_raw = '0;
    logic [3:0]  btn_raw = '0;
    logic [15:0] sw_clean;
    logic [3:0]  btn_clean;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    switch_debounce #(.SW_W(16), .BTN_W(4), .TICK_MAX(TICK)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sw_raw    (sw_raw),
        .btn_raw   (btn_raw),
        .sw_clean  (sw_clean),
        .btn_clean (btn_clean)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R3 monitor: output changes must sit on a 2*(TICK+1) grid
    int          cyc = 0;
    int          ref_cyc = 0;
    bit          ref_ok = 1'b0;
    logic [19:0] prev_out = '0;
    always @(posedge clk) begin
        #1;
        if (rst) begin
            cyc    = 0;
            ref_ok = 1'b0;
        end else begin
            cyc++;
            if ({btn_clean, sw_clean} != prev_out) begin
                if (!ref_ok) begin
                    ref_ok  = 1'b1;
                    ref_cyc = cyc;
                end else begin
                    check("R3 change spacing mod pair", (cyc - ref_cyc) % PAIR, 0);
                end
            end
        end
        prev_out = {btn_clean, sw_clean};
    end

    task automatic t_reset();
        sw_raw  = 16'hA5C3;
        btn_raw = 4'hF;
        rst     = 1'b1;
        wait_cycles(5);
        check("R1 sw reset", sw_clean, 0);
        check("R1 btn reset", btn_clean, 0);
        sw_raw  = '0;
        btn_raw = '0;
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(2);
    endtask

    task automatic t_propagate(input logic [15:0] s, input logic [3:0] b);
        logic [15:0] old_s;
        old_s = sw_clean;
        @(negedge clk);
        sw_raw  = s;
        btn_raw = b;
        wait_cycles(2);
        check("R6 no change within two edges", sw_clean, old_s);
        wait_cycles(BOUND - 2);
        check("R2 sw propagated", sw_clean, s);
        check("R2 btn propagated", btn_clean, b);
    endtask

    task automatic t_glitch(input logic [15:0] g);
        logic [15:0] base;
        base = sw_clean;
        for (int off = 0; off < PER; off++) begin
            wait_cycles(off + 1);
            sw_raw = base ^ g;
            wait_cycles(3);
            sw_raw = base;
            wait_cycles(BOUND);
            check("R4 glitch rejected", sw_clean, base);
        end
    endtask

    task automatic t_independent();
        logic [3:0] btn_before;
        logic [3:0] pat;
        btn_before = btn_clean;
        pat = btn_before + 4'd1;
        @(negedge clk);
        sw_raw = 16'h0F0F;
        for (int i = 0; i < 2 * BOUND; i++) begin
            if (i % 7 == 0) begin
                btn_raw = pat;
                pat = pat + 4'd1;
                if (pat == btn_before) pat = pat + 4'd1;
            end
            @(negedge clk);
        end
        check("R5 sw updates while btn bounces", sw_clean, 16'h0F0F);
        check("R5 bouncing btn keeps value", btn_clean, btn_before);
        btn_raw = 4'h9;
        wait_cycles(BOUND);
        check("R5 btn updates once stable", btn_clean, 4'h9);
        check("R5 sw unaffected", sw_clean, 16'h0F0F);
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        #0.5;
        rst = 1'b1;
        #0.5;
        check("R1 async sw clear", sw_clean, 0);
        check("R1 async btn clear", btn_clean, 0);
        sw_raw  = '0;
        btn_raw = '0;
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(2);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        check("R2 idle zero sw", sw_clean, 0);
        t_propagate(16'h1234, 4'h5);
        t_propagate(16'hFFFF, 4'hA);
        t_propagate(16'h8001, 4'h0);
        t_glitch(16'h0040);
        t_glitch(16'hFFFF);
        t_independent();
        t_async_reset();
        t_propagate(16'h5A5A, 4'h3);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 4);
                fails++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule